// File: doc/BRIEF.md
# Four-Cell Configurable Logic Block

This block is a synthesizable behavioural model of one programmable logic tile. It holds four identical cells, indexed 0 to 3. Each cell has a 4-input lookup table whose 16 truth-table bits come from a static configuration word, and one storage bit. The storage bit can act as an edge-triggered flip-flop or as a level-sensitive transparent latch. Adjacent cell pairs can be merged through a 2:1 selector into 5-input functions. A ripple carry path runs from cell 0 to cell 3. Four bus drivers share one enable.

The model runs on a fabric clock `clk` with a synchronous active-high `rst`. The emulated block clock `blk_clk` is an ordinary input that is sampled on every fabric edge. A flip-flop edge is therefore an edge of the sampled block clock, seen after the cell's polarity bit is applied. A latch is transparent while that polarity-adjusted level is high. The clock enable and the clear are shared by all four cells. The clear acts at the next fabric edge and wins over the enable and the block clock.

The configuration inputs are expected to stay constant while the block is in use.

Top module: `lb_block`

## Requirements
- R1: While `rst` is high at a fabric edge, every `q_out` bit becomes 0 and the previous block-clock sample is taken as 0.
- R2: `lut_out[i]` equals bit `16*i + cell_in[4*i+3:4*i]` of `cfg_lut`.
- R3: `f5_out[j]` equals `lut_out[2*j+1]` when `f5_sel[j]` is 1, and `lut_out[2*j]` otherwise.
- R4: With c0 = `carry_in`, cell i uses p = `lut_out[i]`. Then `sum_out[i]` = p xor c_i, and c_(i+1) is c_i when p is 1 and `cell_in[4*i]` when p is 0. `carry_out` is c_4.
- R5: The storage input of cell i is chosen by `cfg_dsrc[2*i+1:2*i]`: 0 selects the cell's LUT output, 1 selects `cell_dir[i]`, 2 selects `sum_out[i]`, and 3 selects `f5_out[i/2]`.
- R6: With `cfg_latch[i]`=0, cell i loads its storage input at a fabric edge only when three conditions hold: `blk_ce` is 1, the effective clock (`blk_clk` xor `cfg_clkinv[i]`) is 1, and that effective clock was 0 at the previous fabric edge. Otherwise the cell holds. The new value shows on `q_out[i]` after that edge.
- R7: With `cfg_clkinv[i]`=1, a flip-flop cell loads on a 1-to-0 change of `blk_clk` instead of a 0-to-1 change, and each cell keeps its own polarity.
- R8: With `cfg_latch[i]`=1, cell i loads its storage input at every fabric edge where the effective clock is 1 and `blk_ce` is 1. It holds while the effective clock is 0.
- R9: With `blk_ce`=0, no cell changes in either mode, whatever `blk_clk` does.
- R10: `blk_clr`=1 at a fabric edge zeros every `q_out` bit, regardless of `blk_ce` and `blk_clk`.
- R11: With `tbuf_oe`=1, `tbuf_bus[i]` drives `lut_out[i]` when `cfg_tsrc[i]`=1 and `q_out[i]` when it is 0. With `tbuf_oe`=0, all four lines are released to high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lut | input | 64 | Truth tables, 16 bits per cell |
| cfg_dsrc | input | 8 | Storage input source, 2 bits per cell |
| cfg_latch | input | 4 | 1 = transparent latch, 0 = flip-flop |
| cfg_clkinv | input | 4 | Per-cell block-clock inversion |
| cfg_tsrc | input | 4 | Bus driver source: 1 = LUT, 0 = stored bit |
| cell_in | input | 16 | Four data inputs per cell |
| cell_dir | input | 4 | Direct storage inputs that bypass the LUT |
| f5_sel | input | 2 | Fifth input of each pair selector |
| blk_clk | input | 1 | Emulated block clock, sampled on `clk` |
| blk_ce | input | 1 | Shared clock enable |
| blk_clr | input | 1 | Shared clear |
| carry_in | input | 1 | Carry into cell 0 |
| carry_out | output | 1 | Carry out of cell 3 |
| lut_out | output | 4 | Combinational LUT outputs |
| f5_out | output | 2 | Combinational 5-input function outputs |
| sum_out | output | 4 | Combinational carry-chain sums |
| q_out | output | 4 | Stored bits |
| tbuf_oe | input | 1 | Shared bus driver enable |
| tbuf_bus | output | 4 | Tri-state bus lines |

## Verification
The LUT, pair-selector and carry results depend only on the inputs of the current cycle. Each one is compared at the first fabric rising edge after the stimulus, 5 ns past that edge and before the driver moves again. A stored bit passes through one register, so it is due at the same edge that samples the block-clock level, enable and clear which load it. The bus lines follow the stored bit or the LUT with no further delay. The driver applies stimulus on the falling fabric edge and queues every expected value tagged for the next rising edge. The monitor pops and compares a value only when its due edge arrives.

// File: rtl/lb_pkg.sv
`timescale 1ns/1ps
package lb_pkg;
  // Storage input selector encoding (per cell, 2 bits).
  typedef enum logic [1:0] {
    DSRC_LUT    = 2'd0,
    DSRC_DIRECT = 2'd1,
    DSRC_SUM    = 2'd2,
    DSRC_WIDE   = 2'd3
  } dsrc_e;

  // Level of the block clock after the per-cell polarity bit.
  function automatic logic eff_level(input logic clk_lvl, input logic invert);
    return clk_lvl ^ invert;
  endfunction
endpackage

// File: rtl/lb_lut.sv
`timescale 1ns/1ps
module lb_lut #(
  parameter int K = 4,
  localparam int NBITS = 1 << K
) (
  input  logic [NBITS-1:0] table_bits,
  input  logic [K-1:0]     sel,
  output logic             y
);
  assign y = table_bits[sel];
endmodule

// File: rtl/lb_carry.sv
`timescale 1ns/1ps
module lb_carry #(
  parameter int N = 4
) (
  input  logic [N-1:0] prop,
  input  logic [N-1:0] gen,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N:0] chain;
  assign chain[0] = cin;
  for (genvar i = 0; i < N; i++) begin : g_stage
    assign sum[i]     = prop[i] ^ chain[i];
    assign chain[i+1] = prop[i] ? chain[i] : gen[i];
  end
  assign cout = chain[N];
endmodule

// File: rtl/lb_store.sv
`timescale 1ns/1ps
module lb_store (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ce,
  input  logic latch_mode,
  input  logic eff_now,
  input  logic eff_prev,
  input  logic d,
  output logic q
);
  logic load;
  always_comb begin
    if (latch_mode) load = ce & eff_now;
    else            load = ce & eff_now & ~eff_prev;
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/lb_block.sv
`timescale 1ns/1ps
module lb_block
  import lb_pkg::*;
#(
  parameter int NCELL = 4,
  parameter int LUT_K = 4,
  localparam int LUT_BITS = 1 << LUT_K,
  localparam int NPAIR = NCELL / 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCELL*LUT_BITS-1:0] cfg_lut,
  input  logic [NCELL*2-1:0]        cfg_dsrc,
  input  logic [NCELL-1:0]          cfg_latch,
  input  logic [NCELL-1:0]          cfg_clkinv,
  input  logic [NCELL-1:0]          cfg_tsrc,
  input  logic [NCELL*LUT_K-1:0]    cell_in,
  input  logic [NCELL-1:0]          cell_dir,
  input  logic [NPAIR-1:0]          f5_sel,
  input  logic                      blk_clk,
  input  logic                      blk_ce,
  input  logic                      blk_clr,
  input  logic                      carry_in,
  output logic                      carry_out,
  output logic [NCELL-1:0]          lut_out,
  output logic [NPAIR-1:0]          f5_out,
  output logic [NCELL-1:0]          sum_out,
  output logic [NCELL-1:0]          q_out,
  input  logic                      tbuf_oe,
  output logic [NCELL-1:0]          tbuf_bus
);
  logic             blk_clk_q;
  logic [NCELL-1:0] gen_vec;
  logic [NCELL-1:0] d_vec;

  // Previous sample of the emulated block clock.
  always_ff @(posedge clk) begin
    if (rst) blk_clk_q <= 1'b0;
    else     blk_clk_q <= blk_clk;
  end

  // Pair selectors forming 5-input functions.
  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    assign f5_out[j] = f5_sel[j] ? lut_out[2*j+1] : lut_out[2*j];
  end

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic d_sel;
    logic eff_now;
    logic eff_prev;

    lb_lut #(.K(LUT_K)) u_lut (
      .table_bits (cfg_lut[i*LUT_BITS +: LUT_BITS]),
      .sel        (cell_in[i*LUT_K +: LUT_K]),
      .y          (lut_out[i])
    );

    assign gen_vec[i] = cell_in[i*LUT_K];

    always_comb begin
      case (dsrc_e'(cfg_dsrc[2*i +: 2]))
        DSRC_LUT:    d_sel = lut_out[i];
        DSRC_DIRECT: d_sel = cell_dir[i];
        DSRC_SUM:    d_sel = sum_out[i];
        DSRC_WIDE:   d_sel = f5_out[i/2];
        default:     d_sel = lut_out[i];
      endcase
    end
    assign d_vec[i] = d_sel;

    assign eff_now  = eff_level(blk_clk,   cfg_clkinv[i]);
    assign eff_prev = eff_level(blk_clk_q, cfg_clkinv[i]);

    lb_store u_store (
      .clk        (clk),
      .rst        (rst),
      .clr        (blk_clr),
      .ce         (blk_ce),
      .latch_mode (cfg_latch[i]),
      .eff_now    (eff_now),
      .eff_prev   (eff_prev),
      .d          (d_vec[i]),
      .q          (q_out[i])
    );

    assign tbuf_bus[i] = tbuf_oe ? (cfg_tsrc[i] ? lut_out[i] : q_out[i]) : 1'bz;
  end

  lb_carry #(.N(NCELL)) u_carry (
    .prop (lut_out),
    .gen  (gen_vec),
    .cin  (carry_in),
    .sum  (sum_out),
    .cout (carry_out)
  );
endmodule

// File: rtl/lb_block_chk.sv
`timescale 1ns/1ps
module lb_block_chk #(
  parameter int NCELL = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             blk_clk,
  input logic             blk_clk_q,
  input logic             blk_ce,
  input logic             blk_clr,
  input logic [NCELL-1:0] cfg_latch,
  input logic [NCELL-1:0] cfg_clkinv,
  input logic [NCELL-1:0] d_vec,
  input logic [NCELL-1:0] lut_out,
  input logic             carry_in,
  input logic             carry_out,
  input logic [NCELL-1:0] q_out
);
  // R1
  rst_zero_chk: assert property (@(posedge clk) rst |=> (q_out == '0));

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    blk_clr |=> (q_out == '0));

  // R9
  ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!blk_clr && !blk_ce) |=> $stable(q_out));

  // R4
  carry_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (&lut_out) |-> (carry_out == carry_in));

  for (genvar i = 0; i < NCELL; i++) begin : g_cell_chk
    logic e_now, e_prev;
    assign e_now  = blk_clk   ^ cfg_clkinv[i];
    assign e_prev = blk_clk_q ^ cfg_clkinv[i];

    // R6
    ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_latch[i] && !blk_clr && !(e_now && !e_prev)) |=> $stable(q_out[i]));

    // R8
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_latch[i] && e_now && blk_ce && !blk_clr) |=> (q_out[i] == $past(d_vec[i])));
  end
endmodule

bind lb_block lb_block_chk #(.NCELL(NCELL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .blk_clk    (blk_clk),
  .blk_clk_q  (blk_clk_q),
  .blk_ce     (blk_ce),
  .blk_clr    (blk_clr),
  .cfg_latch  (cfg_latch),
  .cfg_clkinv (cfg_clkinv),
  .d_vec      (d_vec),
  .lut_out    (lut_out),
  .carry_in   (carry_in),
  .carry_out  (carry_out),
  .q_out      (q_out)
);

// File: tb/lb_block_tb.sv
`timescale 1ns/1ps
module lb_block_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cfg_lut = '0;
  logic [7:0]  cfg_dsrc = '0;
  logic [3:0]  cfg_latch = '0, cfg_clkinv = '0, cfg_tsrc = '0;
  logic [15:0] cell_in = '0;
  logic [3:0]  cell_dir = '0;
  logic [1:0]  f5_sel = '0;
  logic        blk_clk = 1'b0, blk_ce = 1'b0, blk_clr = 1'b0, carry_in = 1'b0, tbuf_oe = 1'b0;
  logic        carry_out;
  logic [3:0]  lut_out, sum_out, q_out;
  logic [1:0]  f5_out;
  wire  [3:0]  bus;

  for (genvar g = 0; g < 4; g++) begin : g_pu
    pullup pu (bus[g]);
  end

  lb_block u_dut (
    .clk(clk), .rst(rst), .cfg_lut(cfg_lut), .cfg_dsrc(cfg_dsrc), .cfg_latch(cfg_latch),
    .cfg_clkinv(cfg_clkinv), .cfg_tsrc(cfg_tsrc), .cell_in(cell_in), .cell_dir(cell_dir),
    .f5_sel(f5_sel), .blk_clk(blk_clk), .blk_ce(blk_ce), .blk_clr(blk_clr),
    .carry_in(carry_in), .carry_out(carry_out), .lut_out(lut_out), .f5_out(f5_out),
    .sum_out(sum_out), .q_out(q_out), .tbuf_oe(tbuf_oe), .tbuf_bus(bus)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Staged stimulus, applied by the driver at a falling edge.
  logic        s_rst = 1'b1;
  logic [63:0] s_lut = '0;
  logic [7:0]  s_dsrc = '0;
  logic [3:0]  s_latch = '0, s_inv = '0, s_tsrc = '0, s_dir = '0;
  logic [15:0] s_in = '0;
  logic [1:0]  s_f5 = '0;
  logic        s_bclk = 1'b0, s_ce = 1'b0, s_clr = 1'b0, s_ci = 1'b0, s_oe = 1'b0;

  // Reference state.
  logic [3:0] m_q = '0;
  logic       m_prev = 1'b0;

  typedef struct {
    int          due;
    int          req;
    int          kind;
    logic [3:0]  exp;
  } item_t;
  item_t sb[$];

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  function automatic void push(int req, int kind, logic [3:0] exp);
    item_t it;
    it.due = cyc + 1; it.req = req; it.kind = kind; it.exp = exp;
    sb.push_back(it);
  endfunction

  // Driver: applies the staged inputs and queues expected results.
  task automatic step(input int qreq);
    logic [3:0] l, su, d, bx;
    logic [1:0] f;
    logic       c, e, ep;
    @(negedge clk);
    rst = s_rst; cfg_lut = s_lut; cfg_dsrc = s_dsrc; cfg_latch = s_latch;
    cfg_clkinv = s_inv; cfg_tsrc = s_tsrc; cell_in = s_in; cell_dir = s_dir;
    f5_sel = s_f5; blk_clk = s_bclk; blk_ce = s_ce; blk_clr = s_clr;
    carry_in = s_ci; tbuf_oe = s_oe;
    for (int i = 0; i < 4; i++) l[i] = s_lut[16*i + int'(s_in[4*i +: 4])];
    for (int j = 0; j < 2; j++) f[j] = s_f5[j] ? l[2*j+1] : l[2*j];
    c = s_ci;
    for (int i = 0; i < 4; i++) begin
      su[i] = l[i] ^ c;
      c = l[i] ? c : s_in[4*i];
    end
    for (int i = 0; i < 4; i++) begin
      case (s_dsrc[2*i +: 2])
        2'd0: d[i] = l[i];
        2'd1: d[i] = s_dir[i];
        2'd2: d[i] = su[i];
        default: d[i] = f[i/2];
      endcase
    end
    if (s_rst) begin
      m_q = '0; m_prev = 1'b0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        e  = s_bclk ^ s_inv[i];
        ep = m_prev ^ s_inv[i];
        if (s_clr) m_q[i] = 1'b0;
        else if (s_ce && (s_latch[i] ? e : (e && !ep))) m_q[i] = d[i];
      end
      m_prev = s_bclk;
    end
    for (int i = 0; i < 4; i++) bx[i] = s_oe ? (s_tsrc[i] ? l[i] : m_q[i]) : 1'b1;
    push(2, 0, l);                  // R2
    push(3, 1, {2'b00, f});         // R3
    push(4, 2, su);                 // R4
    push(4, 3, {3'b000, c});        // R4
    push(qreq, 4, m_q);
    push(11, 5, bx);                // R11
  endtask

  // Monitor: compares queued items at their due edge.
  initial begin
    item_t it;
    logic [3:0] act;
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        it = sb.pop_front();
        case (it.kind)
          0: act = lut_out;
          1: act = {2'b00, f5_out};
          2: act = sum_out;
          3: act = {3'b000, carry_out};
          4: act = q_out;
          default: act = bus;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL R%0d kind=%0d cycle=%0d act=%b exp=%b", it.req, it.kind, cyc, act, it.exp);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    s_rst = 1'b1;
    repeat (3) step(1);
    s_rst = 1'b0;

    // R6: rising-edge flip-flop loading the direct inputs
    s_dsrc = 8'h55; s_ce = 1'b1; s_oe = 1'b1;
    s_dir = 4'b1010; s_bclk = 1'b0; step(6);
    s_bclk = 1'b1; step(6);
    s_dir = 4'b0101; step(6);
    s_bclk = 1'b0; step(6);
    s_bclk = 1'b1; step(6);
    s_dir = 4'b1111; step(6);

    // R7: inverted polarity, then mixed polarities
    s_inv = 4'b1111; s_dir = 4'b0011; s_bclk = 1'b1; step(7);
    s_bclk = 1'b0; step(7);
    s_dir = 4'b1100; step(7);
    s_bclk = 1'b1; step(7);
    s_inv = 4'b0101; s_dir = 4'b0110;
    for (int k = 0; k < 6; k++) begin
      s_bclk = ~s_bclk; s_dir = s_dir ^ 4'b1001; step(7);
    end

    // R8: transparent latches
    s_inv = 4'b0000; s_latch = 4'b1111; s_bclk = 1'b1;
    for (int k = 0; k < 4; k++) begin
      s_dir = 4'(k * 5 + 3); step(8);
    end
    s_bclk = 1'b0; s_dir = 4'b0000; step(8);
    s_dir = 4'b1111; step(8);

    // R9: enable low, both modes, block clock toggling
    s_ce = 1'b0; s_latch = 4'b0011;
    for (int k = 0; k < 6; k++) begin
      s_bclk = ~s_bclk; s_dir = ~s_dir; step(9);
    end

    // R10: clear wins over enable and an active edge
    s_ce = 1'b1; s_latch = 4'b1111; s_bclk = 1'b1; s_dir = 4'b1111; step(10);
    s_clr = 1'b1; step(10);
    s_latch = 4'b0000; s_bclk = 1'b0; step(10);
    s_bclk = 1'b1; step(10);
    s_clr = 1'b0; step(10);

    // R4: carry chain as a 4-bit adder (LUT = XOR of inputs 0 and 1)
    s_lut = {4{16'h6666}}; s_dsrc = 8'hAA; s_latch = 4'b1111; s_bclk = 1'b1;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int ci = 0; ci < 2; ci++) begin
          for (int i = 0; i < 4; i++)
            s_in[4*i +: 4] = {2'($urandom_range(0, 3)), b[i], a[i]};
          s_ci = ci[0];
          step(4);
        end

    // R2: every truth-table pattern on every cell
    s_ce = 1'b0; s_ci = 1'b0;
    for (int k = 0; k < 65536; k++) begin
      for (int i = 0; i < 4; i++) begin
        s_lut[16*i +: 16] = 16'(k) ^ 16'(16'h1111 * i);
        s_in[4*i +: 4] = 4'(k + 5 * i + (k >> 4));
      end
      step(2);
    end

    // R3, R5, R11: random configurations with loading latches
    s_ce = 1'b1; s_latch = 4'b1111; s_bclk = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      s_lut = {$urandom, $urandom};
      s_in = 16'($urandom); s_dir = 4'($urandom); s_f5 = 2'($urandom);
      s_dsrc = 8'($urandom); s_tsrc = 4'($urandom); s_ci = 1'($urandom);
      s_oe = 1'($urandom);
      step(5);
    end

    // R11: released bus while stored bits are 0
    s_clr = 1'b1; s_oe = 1'b1; s_tsrc = 4'b0000; step(11);
    s_clr = 1'b0; s_ce = 1'b0; s_oe = 1'b0; step(11);
    s_oe = 1'b1; step(11);

    // R6, R7, R8, R9, R10: mixed modes under random clock, enable and clear
    for (int k = 0; k < 3000; k++) begin
      s_latch = 4'($urandom); s_inv = 4'($urandom); s_bclk = 1'($urandom);
      s_ce = ($urandom_range(0, 3) != 0); s_clr = ($urandom_range(0, 15) == 0);
      s_lut = {$urandom, $urandom}; s_in = 16'($urandom); s_dir = 4'($urandom);
      s_dsrc = 8'($urandom); s_f5 = 2'($urandom); s_oe = 1'($urandom);
      step(6);
    end

    // R1: reset from a loaded state
    s_clr = 1'b0; s_ce = 1'b1; s_latch = 4'b1111; s_bclk = 1'b1;
    s_dsrc = 8'h55; s_dir = 4'b1111; step(1);
    s_rst = 1'b1; step(1);
    s_rst = 1'b0; s_ce = 1'b0; step(1);

    repeat (3) @(posedge clk);
    #8;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule